// File: doc/BRIEF.md
# Timer Input Conditioner

This block sits between five asynchronous pins and the event logic of a timer. It produces two views of every pin. The raw view is the pin captured on each rising edge of the timer clock, with no filtering. The event view is the value the event logic acts on.

For each input, one configuration bit chooses the event view. When the bit is set, the event view comes through a three-stage synchronizer and lags the pin by three clocks. When the bit is clear, the event view is the raw view.

Software reaches the block through a small register port. One address holds the synchronizer mask, which can be read and written. A second address is a read-only status word that shows both views side by side. Reads return data one clock after the request. When the mask is changed during operation, the event view switches source on the next edge and the synchronizer chain is not disturbed.

Top module: `tmr_in_cond`

## Requirements
- R1: After reset, `raw_o`, `evt_o` and `rdata_o` are all zero, and the mask register reads back as 5'h1F, which means every input is synchronized.
- R2: After every rising edge, `raw_o` equals `pin_i` as it was sampled at that edge.
- R3: For an input whose mask bit is 1, `evt_o` equals the pin value sampled two edges before the most recent edge. A pin change therefore appears on `evt_o` at the third rising edge after it.
- R4: For an input whose mask bit is 0, `evt_o` equals `raw_o`.
- R5: The status word at address 1 carries the raw view in bits 4:0 and the event view in bits 20:16. Bits 15:5 and bits 31:21 are zero.
- R6: A read (`req_i`=1, `wr_i`=0) returns the register contents from before the edge on `rdata_o`, one edge later. `rdata_o` holds its value on cycles without a read.
- R7: A write to address 1 changes neither the mask nor `rdata_o`.
- R8: A write to address 0 loads the mask from `wdata_i[4:0]`. Address 0 reads back the mask in bits 4:0 with zeros above. Addresses 2 and 3 read as zero.
- R9: A change of the mask takes effect on `evt_o` at the edge that loads it, and the synchronizer chain keeps its contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 5 | Asynchronous input pins |
| req_i | input | 1 | Register access request |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 2 | Register word address (0 = mask, 1 = status) |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid one edge after a read |
| raw_o | output | 5 | Raw sampled view |
| evt_o | output | 5 | Event-path view |

## Verification
The bench drives one pin edge while every input is synchronized and counts edges until the event view follows. A chain that is one stage short or one stage long shows the change on the wrong edge. It changes the mask in the same cycle as a pin transition, then sets the mask again. A design that registers the mux, or clears the chain when the mask changes, then shows a stale value or a zero where the old samples should come through. It also writes to the read-only status address and reads unmapped addresses, which exposes a decode that leaks a write into the mask or returns stale data. Random pins with random reads and mask changes are compared on every clock against a history-queue model, which covers the field positions of the status word.

// File: rtl/tic_pkg.sv
package tic_pkg;
    localparam int unsigned SYNC_STAGES = 3;

    typedef enum logic [1:0] {
        SEL_MASK = 2'd0,
        SEL_STAT = 2'd1
    } reg_sel_e;
endpackage

// File: rtl/tic_sampler.sv
module tic_sampler
    import tic_pkg::*;
#(
    parameter int unsigned N_IN = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_IN-1:0] pin_i,
    input  logic [N_IN-1:0] mask_i,
    output logic [N_IN-1:0] raw_o,
    output logic [N_IN-1:0] evt_o
);
    // The raw flop is the first synchronizer stage; only the later stages are added.
    localparam int unsigned EXTRA = SYNC_STAGES - 1;

    typedef struct packed {
        logic [N_IN-1:0]            raw;
        logic [EXTRA-1:0][N_IN-1:0] chain;
    } smp_t;

    smp_t smp_d, smp_q;

    always_comb begin
        smp_d          = smp_q;
        smp_d.raw      = pin_i;
        smp_d.chain[0] = smp_q.raw;
        for (int s = 1; s < int'(EXTRA); s++) begin
            smp_d.chain[s] = smp_q.chain[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) smp_q <= '0;
        else        smp_q <= smp_d;
    end

    assign raw_o = smp_q.raw;

    // One mux per input picks the synchronized or the raw source.
    for (genvar i = 0; i < int'(N_IN); i++) begin : g_sel
        assign evt_o[i] = mask_i[i] ? smp_q.chain[EXTRA-1][i] : smp_q.raw[i];
    end

    // R3
    sync_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        smp_q.chain[EXTRA-1] == $past(smp_q.raw, 2));
endmodule

// File: rtl/tic_regs.sv
module tic_regs
    import tic_pkg::*;
#(
    parameter int unsigned N_IN    = 5,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned ADDR_W  = 2,
    parameter int unsigned EVT_LSB = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [N_IN-1:0]   raw_i,
    input  logic [N_IN-1:0]   evt_i,
    output logic [N_IN-1:0]   mask_o,
    output logic [DATA_W-1:0] rdata_o
);
    typedef struct packed {
        logic [N_IN-1:0]   mask;
        logic [DATA_W-1:0] rdata;
    } reg_t;

    reg_t reg_d, reg_q;
    logic [DATA_W-1:0] mask_word, stat_word;
    logic              sel_mask, sel_stat;

    assign sel_mask = (addr_i == ADDR_W'(SEL_MASK));
    assign sel_stat = (addr_i == ADDR_W'(SEL_STAT));

    always_comb begin
        mask_word              = '0;
        mask_word[N_IN-1:0]    = reg_q.mask;
        stat_word              = '0;
        stat_word[N_IN-1:0]    = raw_i;
        stat_word[EVT_LSB +: N_IN] = evt_i;
    end

    always_comb begin
        reg_d = reg_q;
        if (req_i && wr_i && sel_mask) begin
            reg_d.mask = wdata_i[N_IN-1:0];
        end
        if (req_i && !wr_i) begin
            if (sel_mask)      reg_d.rdata = mask_word;
            else if (sel_stat) reg_d.rdata = stat_word;
            else               reg_d.rdata = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_q.mask  <= '1;
            reg_q.rdata <= '0;
        end else begin
            reg_q <= reg_d;
        end
    end

    assign mask_o  = reg_q.mask;
    assign rdata_o = reg_q.rdata;

    // R7
    mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_i && wr_i && sel_mask) |=> $stable(reg_q.mask));

    // R6
    rdata_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_i && !wr_i) |=> $stable(rdata_o));

    // R5
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_o[EVT_LSB-1:N_IN] == '0 && rdata_o[DATA_W-1:EVT_LSB+N_IN] == '0);
endmodule

// File: rtl/tmr_in_cond.sv
module tmr_in_cond
    import tic_pkg::*;
#(
    parameter int unsigned N_IN    = 5,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned ADDR_W  = 2,
    parameter int unsigned EVT_LSB = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_IN-1:0]   pin_i,
    input  logic              req_i,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic [N_IN-1:0]   raw_o,
    output logic [N_IN-1:0]   evt_o
);
    logic [N_IN-1:0] mask;

    tic_sampler #(.N_IN(N_IN)) u_smp (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (pin_i),
        .mask_i (mask),
        .raw_o  (raw_o),
        .evt_o  (evt_o)
    );

    tic_regs #(
        .N_IN    (N_IN),
        .DATA_W  (DATA_W),
        .ADDR_W  (ADDR_W),
        .EVT_LSB (EVT_LSB)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (req_i),
        .wr_i    (wr_i),
        .addr_i  (addr_i),
        .wdata_i (wdata_i),
        .raw_i   (raw_o),
        .evt_i   (evt_o),
        .mask_o  (mask),
        .rdata_o (rdata_o)
    );

    // R4
    bypass_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((~mask) & (evt_o ^ raw_o)) == '0);

    // R2
    raw_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> raw_o == $past(pin_i));
endmodule

// File: tb/tmr_in_cond_tb.sv
module tmr_in_cond_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  pin = '0;
    logic        req = 1'b0, wr = 1'b0;
    logic [1:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [4:0]  raw, evt;

    int checks = 0, failures = 0;
    bit run_cmp = 1'b0;

    always #2 clk = ~clk;

    tmr_in_cond u_dut (
        .clk(clk), .rst_n(rst_n), .pin_i(pin), .req_i(req), .wr_i(wr),
        .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .raw_o(raw), .evt_o(evt)
    );

    // Reference model: a history of sampled pins, the mask and the last read.
    logic [4:0]  hist[$];
    logic [4:0]  m_mask;
    logic [31:0] m_rdata;

    function automatic logic [4:0] m_raw();
        return (hist.size() >= 1) ? hist[hist.size()-1] : 5'd0;
    endfunction

    function automatic logic [4:0] m_evt();
        logic [4:0] old;
        old = (hist.size() >= 3) ? hist[hist.size()-3] : 5'd0;
        return (m_mask & old) | (~m_mask & m_raw());
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist.delete();
            m_mask  = 5'h1F;
            m_rdata = '0;
        end else begin
            if (req && !wr) begin
                case (addr)
                    2'd0:    m_rdata = {27'd0, m_mask};
                    2'd1:    m_rdata = {11'd0, m_evt(), 11'd0, m_raw()};
                    default: m_rdata = '0;
                endcase
            end
            if (req && wr && addr == 2'd0) m_mask = wdata[4:0];
            hist.push_back(pin);
            if (hist.size() > 4) void'(hist.pop_front());
        end
    end

    task automatic check(string req_tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h at %0t", req_tag, act, exp, $time);
        end
    endtask

    // Per-clock comparison against the model.
    always @(negedge clk) begin
        if (run_cmp) begin
            check("R2 raw", {27'd0, raw}, {27'd0, m_raw()});
            for (int i = 0; i < 5; i++) begin
                if (m_mask[i]) check("R3 evt sync", {31'd0, evt[i]}, {31'd0, m_evt()[i]});
                else           check("R4 evt bypass", {31'd0, evt[i]}, {31'd0, m_evt()[i]});
            end
            check("R5/R6 rdata", rdata, m_rdata);
        end
    end

    task automatic bus(logic w, logic [1:0] a, logic [31:0] d);
        req = 1'b1; wr = w; addr = a; wdata = d;
        @(negedge clk);
        req = 1'b0; wr = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] keep;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 raw", {27'd0, raw}, 32'd0);
        check("R1 evt", {27'd0, evt}, 32'd0);
        check("R1 rdata", rdata, 32'd0);
        run_cmp = 1'b1;
        bus(1'b0, 2'd0, '0);
        check("R1 mask reset", rdata, 32'h1F);

        // R3: single edge on all pins, every input synchronized
        pin = 5'h00;
        repeat (4) @(negedge clk);
        pin = 5'h1F;
        @(negedge clk);
        check("R3 raw first edge", {27'd0, raw}, 32'h1F);
        check("R3 evt first edge", {27'd0, evt}, 32'h00);
        @(negedge clk);
        check("R3 evt second edge", {27'd0, evt}, 32'h00);
        @(negedge clk);
        check("R3 evt third edge", {27'd0, evt}, 32'h1F);

        // R9: mask change with a pin transition in the same cycle
        repeat (3) @(negedge clk);
        pin = 5'h00;
        bus(1'b1, 2'd0, 32'h0);
        check("R9 bypass at load edge", {27'd0, evt}, 32'h00);
        bus(1'b1, 2'd0, 32'h1F);
        check("R9 chain kept", {27'd0, evt}, 32'h1F);
        @(negedge clk);
        check("R9 chain drains", {27'd0, evt}, 32'h00);

        // R8: mask write/readback and unmapped addresses
        bus(1'b1, 2'd0, 32'hFFFF_FFEA);
        bus(1'b0, 2'd0, '0);
        check("R8 mask readback", rdata, 32'h0A);
        bus(1'b0, 2'd3, '0);
        check("R8 unmapped 3", rdata, 32'h0);
        bus(1'b0, 2'd2, '0);
        check("R8 unmapped 2", rdata, 32'h0);

        // R7: write to the status address is ignored
        pin = 5'h15;
        bus(1'b0, 2'd0, '0);
        keep = rdata;
        bus(1'b1, 2'd1, 32'hFFFF_FFFF);
        check("R7 rdata unchanged by write", rdata, keep);
        bus(1'b0, 2'd0, '0);
        check("R7 mask unchanged", rdata, 32'h0A);

        // R5/R6: status layout with a known steady pin pattern
        pin = 5'h13;
        repeat (4) @(negedge clk);
        bus(1'b0, 2'd1, '0);
        check("R5 status word", rdata, {11'd0, 5'h13, 11'd0, 5'h13});
        repeat (2) @(negedge clk);
        check("R6 rdata held", rdata, {11'd0, 5'h13, 11'd0, 5'h13});

        // Random pins, reads and mask changes, compared every clock
        for (int c = 0; c < 400; c++) begin
            pin = 5'($urandom);
            if (c % 37 == 0)     bus(1'b1, 2'd0, $urandom);
            else if (c % 3 == 0) bus(1'b0, 2'($urandom), '0);
            else                 @(negedge clk);
        end

        run_cmp = 1'b0;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule